// File: doc/BRIEF.md
# Quad DAC Serial Command Decoder

This block is the digital front end of a four-channel, 16-bit voltage-output converter. A host shifts 24-bit command frames in over a three-wire link: a serial clock, an active-low frame strobe and a data line. The block samples all three with its own system clock. A data bit is captured on each falling edge of the serial clock while the strobe is low. When the 24th bit arrives, the frame is decoded into one of three actions: a channel data write, a channel power-state change, or a command for the internal reference mode.

For each channel the block holds an input buffer, an output code, a two-bit power state and an output-enable flag. It also drives a single enable for the internal reference. In automatic mode that enable follows the channel power states. A host can also pin it on or off. The analog converter, the output stages and the reference itself sit outside this block.

Top module: `quad_dac_decoder`

## Requirements
- R1: A frame is 24 bits, shifted MSB first. Bit 23..22 is the address, bit 21..20 is the load field, bit 19 is reserved, bit 18..17 is the channel select (00=A, 01=B, 10=C, 11=D), bit 16 is the command flag, and bits 15..0 are the payload. The frame takes effect on the 24th captured falling edge, and every output it changes moves in the same system cycle.
- R2: A frame whose address field is not 00 has no effect.
- R3: If the strobe rises before 24 bits are captured, the frame is discarded and no output changes. Edges after the 24th bit and before the strobe rises are ignored.
- R4: With the command flag at 0, load 00 stores the payload in the selected channel's buffer without touching its output. Load 01 stores the payload in the selected buffer, copies it to that channel's output and sets that channel's power state to 00. Other channels are untouched.
- R5: With the command flag at 0, load 10 stores the payload in the selected buffer and then copies every buffer to its output, setting all power states to 00.
- R6: With the command flag at 0, load 11 with select 10 writes the payload to all four buffers and outputs and sets all power states to 00. Load 11 with any other select has no effect.
- R7: With the command flag at 1, payload bits 15..14 give a power state (00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 high impedance). Load 01 applies it to the selected channel, and load 11 with select 10 applies it to all channels. Any other load/select combination that is not a reference command has no effect. A channel's output enable is 1 exactly when its power state is 00.
- R8: With the command flag at 1, load 00, select 00 and bit 19 at 0, payload bits 15..12 choose the reference mode: 0000 automatic, 0001 forced on, 0010 forced off. Other values have no effect.
- R9: In automatic mode the reference enable is 1 when at least one channel has power state 00 and 0 when none does. It tracks power-state changes in the same cycle.
- R10: After reset every buffer and output code is 0, every power state is 00, every output enable is 1, the reference is in automatic mode and its enable is 1.
- R11: Output codes, power states and the reference enable change only in the cycle after an accepted frame is assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples the serial link |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; bits are captured on its falling edge |
| sync_ni | input | 1 | Active-low frame strobe |
| din_i | input | 1 | Serial data, MSB first |
| ch_code_o | output | 64 | Output codes, channel A in bits 15..0 up to D in 63..48 |
| ch_pd_o | output | 8 | Power states, two bits per channel, A in 1..0 |
| ch_oe_o | output | 4 | Output enable per channel, A in bit 0 |
| ref_en_o | output | 1 | Internal reference enable |

## Verification
The bench sweeps every combination of address, load, select and command flag over payloads chosen to hit each reference code and each power state, and compares all outputs against a bench-side model after every frame. A decoder that mixed up the buffer-only and transfer loads would show an output moving early, or a stale buffer reaching the output on a later load 10. Truncated and over-long frames are sent deliberately: a design that counted edges loosely would act on a partial frame, or shift trailing bits into a completed one. The automatic reference sequence powers all channels down and then powers one back up, which exposes an enable that latches instead of following the power states.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  typedef enum logic [1:0] {
    REF_AUTO = 2'd0,
    REF_ON   = 2'd1,
    REF_OFF  = 2'd2
  } ref_mode_e;

  localparam int unsigned SEL_W = 2;
  localparam int unsigned HDR_W = 8;
endpackage

// File: rtl/dacq_shift.sv
module dacq_shift #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sync_ni,
  input  logic               din_i,
  output logic               frm_vld_o,
  output logic [FRAME_W-1:0] frm_o
);
  localparam int unsigned CW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);

  logic               sclk_q;
  logic [CW-1:0]      cnt_q;
  logic [FRAME_W-2:0] sr_q;
  logic               fall;

  assign fall = sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      cnt_q     <= '0;
      sr_q      <= '0;
      frm_vld_o <= 1'b0;
      frm_o     <= '0;
    end else begin
      sclk_q    <= sclk_i;
      frm_vld_o <= 1'b0;
      if (sync_ni) begin
        cnt_q <= '0;
      end else if (fall && cnt_q != FULL) begin
        sr_q  <= {sr_q[FRAME_W-3:0], din_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          frm_vld_o <= 1'b1;
          frm_o     <= {sr_q, din_i};
        end
      end
    end
  end
endmodule

// File: rtl/dacq_decode.sv
module dacq_decode
  import dacq_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 16,
  localparam int unsigned FRAME_W = DW + HDR_W
) (
  input  logic               frm_vld_i,
  input  logic [FRAME_W-1:0] frm_i,
  output logic [NCH-1:0]     buf_we_o,
  output logic [NCH-1:0]     out_ld_o,
  output logic [NCH-1:0]     pd_we_o,
  output logic [1:0]         pd_mode_o,
  output logic [DW-1:0]      pay_o,
  output logic               ref_we_o,
  output ref_mode_e          ref_mode_o
);
  localparam logic [SEL_W-1:0] SEL_ALL = SEL_W'(2);

  logic [1:0]       addr, ld;
  logic             rsvd, cmd;
  logic [SEL_W-1:0] sel;
  logic [NCH-1:0]   sel_oh;
  logic [3:0]       ref_code;

  assign addr      = frm_i[FRAME_W-1 -: 2];
  assign ld        = frm_i[FRAME_W-3 -: 2];
  assign rsvd      = frm_i[FRAME_W-5];
  assign sel       = frm_i[FRAME_W-6 -: SEL_W];
  assign cmd       = frm_i[DW];
  assign pay_o     = frm_i[DW-1:0];
  assign ref_code  = frm_i[DW-1 -: 4];
  assign pd_mode_o = frm_i[DW-1 -: 2];

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel_oh[i] = (sel == SEL_W'(i));
  end

  always_comb begin
    buf_we_o   = '0;
    out_ld_o   = '0;
    pd_we_o    = '0;
    ref_we_o   = 1'b0;
    ref_mode_o = REF_AUTO;
    if (frm_vld_i && addr == 2'b00) begin
      if (!cmd) begin
        unique case (ld)
          2'b00: buf_we_o = sel_oh;
          2'b01: begin
            buf_we_o = sel_oh;
            out_ld_o = sel_oh;
          end
          2'b10: begin
            buf_we_o = sel_oh;
            out_ld_o = '1;
          end
          default: begin
            if (sel == SEL_ALL) begin
              buf_we_o = '1;
              out_ld_o = '1;
            end
          end
        endcase
      end else if (ld == 2'b00 && sel == '0 && !rsvd) begin
        unique case (ref_code)
          4'h0: begin ref_we_o = 1'b1; ref_mode_o = REF_AUTO; end
          4'h1: begin ref_we_o = 1'b1; ref_mode_o = REF_ON;   end
          4'h2: begin ref_we_o = 1'b1; ref_mode_o = REF_OFF;  end
          default: ;
        endcase
      end else if (ld == 2'b01) begin
        pd_we_o = sel_oh;
      end else if (ld == 2'b11 && sel == SEL_ALL) begin
        pd_we_o = '1;
      end
    end
  end
endmodule

// File: rtl/dacq_bank.sv
module dacq_bank #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    buf_we_i,
  input  logic [NCH-1:0]    out_ld_i,
  input  logic [NCH-1:0]    pd_we_i,
  input  logic [1:0]        pd_mode_i,
  input  logic [DW-1:0]     pay_i,
  output logic [NCH*DW-1:0] code_o,
  output logic [NCH*2-1:0]  pd_o,
  output logic [NCH-1:0]    oe_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] buf_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q             <= '0;
        code_o[i*DW +: DW] <= '0;
        pd_o[2*i +: 2]    <= 2'b00;
        oe_o[i]           <= 1'b1;
      end else begin
        if (buf_we_i[i]) buf_q <= pay_i;
        if (out_ld_i[i]) begin
          // same-frame buffer write reaches the output directly
          code_o[i*DW +: DW] <= buf_we_i[i] ? pay_i : buf_q;
          pd_o[2*i +: 2]     <= 2'b00;
          oe_o[i]            <= 1'b1;
        end else if (pd_we_i[i]) begin
          pd_o[2*i +: 2] <= pd_mode_i;
          oe_o[i]        <= (pd_mode_i == 2'b00);
        end
      end
    end
  end
endmodule

// File: rtl/dacq_ref.sv
module dacq_ref
  import dacq_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_we_i,
  input  ref_mode_e      ref_mode_i,
  input  logic [NCH-1:0] oe_i,
  output logic           ref_en_o
);
  ref_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= REF_AUTO;
    else if (ref_we_i) mode_q <= ref_mode_i;
  end

  always_comb begin
    unique case (mode_q)
      REF_ON:  ref_en_o = 1'b1;
      REF_OFF: ref_en_o = 1'b0;
      default: ref_en_o = |oe_i;
    endcase
  end
endmodule

// File: rtl/quad_dac_decoder.sv
module quad_dac_decoder
  import dacq_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sync_ni,
  input  logic              din_i,
  output logic [NCH*DW-1:0] ch_code_o,
  output logic [NCH*2-1:0]  ch_pd_o,
  output logic [NCH-1:0]    ch_oe_o,
  output logic              ref_en_o
);
  localparam int unsigned FRAME_W = DW + HDR_W;

  logic               frm_vld;
  logic [FRAME_W-1:0] frm;
  logic [NCH-1:0]     buf_we, out_ld, pd_we;
  logic [1:0]         pd_mode;
  logic [DW-1:0]      pay;
  logic               ref_we;
  ref_mode_e          ref_mode;

  dacq_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .sync_ni   (sync_ni),
    .din_i     (din_i),
    .frm_vld_o (frm_vld),
    .frm_o     (frm)
  );

  dacq_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .frm_vld_i  (frm_vld),
    .frm_i      (frm),
    .buf_we_o   (buf_we),
    .out_ld_o   (out_ld),
    .pd_we_o    (pd_we),
    .pd_mode_o  (pd_mode),
    .pay_o      (pay),
    .ref_we_o   (ref_we),
    .ref_mode_o (ref_mode)
  );

  dacq_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .buf_we_i  (buf_we),
    .out_ld_i  (out_ld),
    .pd_we_i   (pd_we),
    .pd_mode_i (pd_mode),
    .pay_i     (pay),
    .code_o    (ch_code_o),
    .pd_o      (ch_pd_o),
    .oe_o      (ch_oe_o)
  );

  dacq_ref #(.NCH(NCH)) u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_we_i   (ref_we),
    .ref_mode_i (ref_mode),
    .oe_i       (ch_oe_o),
    .ref_en_o   (ref_en_o)
  );
endmodule

// File: rtl/quad_dac_decoder_chk.sv
module quad_dac_decoder_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_ni,
  input logic              frm_vld,
  input logic [NCH*DW-1:0] ch_code_o,
  input logic [NCH*2-1:0]  ch_pd_o,
  input logic [NCH-1:0]    ch_oe_o,
  input logic              ref_en_o
);
  // R11
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frm_vld) |-> $stable(ch_code_o));

  // R11
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frm_vld) |-> $stable(ch_pd_o));

  // R11
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frm_vld) |-> $stable(ref_en_o));

  // R1
  frame_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld |-> !$past(sync_ni));

  // R3
  frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld |=> !frm_vld);

  for (genvar i = 0; i < NCH; i++) begin : g_oe
    // R7
    oe_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_oe_o[i] == (ch_pd_o[2*i +: 2] == 2'b00));
  end
endmodule

bind quad_dac_decoder quad_dac_decoder_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_ni   (sync_ni),
  .frm_vld   (frm_vld),
  .ch_code_o (ch_code_o),
  .ch_pd_o   (ch_pd_o),
  .ch_oe_o   (ch_oe_o),
  .ref_en_o  (ref_en_o)
);

// File: tb/quad_dac_decoder_test.sv
module quad_dac_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0, sync_n = 1'b1, din = 1'b0;
  logic [63:0] code;
  logic [7:0]  pd;
  logic [3:0]  oe;
  logic        ref_en;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [15:0] m_buf [4];
  logic [15:0] m_out [4];
  logic [1:0]  m_pd  [4];
  int          m_ref;

  always #2.5 clk = ~clk;

  quad_dac_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sync_ni(sync_n), .din_i(din),
    .ch_code_o(code), .ch_pd_o(pd), .ch_oe_o(oe), .ref_en_o(ref_en)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic any_on = 1'b0;
    for (int c = 0; c < 4; c++) begin
      chk(tag, $sformatf("code ch%0d", c), 32'(code[c*16 +: 16]), 32'(m_out[c]));
      chk(tag, $sformatf("pd ch%0d", c), 32'(pd[2*c +: 2]), 32'(m_pd[c]));
      chk(tag, $sformatf("oe ch%0d", c), 32'(oe[c]), 32'(m_pd[c] == 2'b00));
      if (m_pd[c] == 2'b00) any_on = 1'b1;
    end
    chk(tag, "ref_en", 32'(ref_en),
        32'((m_ref == 1) ? 1'b1 : (m_ref == 2) ? 1'b0 : any_on));
  endtask

  task automatic model_apply(input logic [23:0] f);
    int a = int'(f[23:22]);
    int ld = int'(f[21:20]);
    int s = int'(f[18:17]);
    logic rsv = f[19];
    logic cm = f[16];
    logic [15:0] p = f[15:0];
    if (a != 0) return;
    if (!cm) begin
      case (ld)
        0: m_buf[s] = p;
        1: begin m_buf[s] = p; m_out[s] = p; m_pd[s] = 2'b00; end
        2: begin
          m_buf[s] = p;
          for (int c = 0; c < 4; c++) begin m_out[c] = m_buf[c]; m_pd[c] = 2'b00; end
        end
        default: if (s == 2)
          for (int c = 0; c < 4; c++) begin
            m_buf[c] = p; m_out[c] = p; m_pd[c] = 2'b00;
          end
      endcase
    end else if (ld == 0 && s == 0 && !rsv) begin
      case (p[15:12])
        4'h0: m_ref = 0;
        4'h1: m_ref = 1;
        4'h2: m_ref = 2;
        default: ;
      endcase
    end else if (ld == 1) begin
      m_pd[s] = p[15:14];
    end else if (ld == 3 && s == 2) begin
      for (int c = 0; c < 4; c++) m_pd[c] = p[15:14];
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    @(negedge clk);
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = n - 1; b >= 0; b--) begin
      din  = v[b];
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    sync_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [23:0] f, input string tag);
    send_bits(32'(f), 24);
    model_apply(f);
    check_all(tag);
  endtask

  function automatic string tag_of(input logic [23:0] f);
    if (f[23:22] != 2'b00) return "R2";
    if (!f[16]) begin
      case (f[21:20])
        2'b00, 2'b01: return "R4";
        2'b10: return "R5";
        default: return "R6";
      endcase
    end
    if (f[21:20] == 2'b00 && f[18:17] == 2'b00) return "R8";
    return "R7";
  endfunction

  initial begin
    for (int c = 0; c < 4; c++) begin m_buf[c] = '0; m_out[c] = '0; m_pd[c] = '0; end
    m_ref = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R10");

    // R1: field order and MSB-first shifting, channel B transfer
    send_frame({2'b00, 2'b01, 1'b0, 2'b01, 1'b0, 16'h8421}, "R1");
    send_frame({2'b00, 2'b01, 1'b0, 2'b11, 1'b0, 16'h0001}, "R1");

    // R3: truncated broadcast is dropped
    send_bits(32'({2'b00, 2'b11, 1'b0, 2'b10, 1'b0, 16'hBEEF} >> 1), 23);
    check_all("R3");
    // R3: two trailing bits after a full frame are ignored
    send_bits({6'b0, 2'b00, 2'b01, 1'b0, 2'b10, 1'b0, 16'h5A5A, 2'b11}, 26);
    model_apply({2'b00, 2'b01, 1'b0, 2'b10, 1'b0, 16'h5A5A});
    check_all("R3");

    // R9: automatic reference follows power states
    send_frame(24'h010000, "R9");
    send_frame(24'h35C000, "R9");
    send_frame(24'h101234, "R9");
    send_frame(24'h234000, "R9");
    send_frame(24'h258000, "R9");

    // sweep of header fields over selected payloads
    for (int a = 0; a < 4; a++)
      for (int ld = 0; ld < 4; ld++)
        for (int s = 0; s < 4; s++)
          for (int cm = 0; cm < 2; cm++)
            for (int k = 0; k < 6; k++) begin
              logic [15:0] p;
              logic [23:0] f;
              case (k)
                0: p = 16'h1ABC;
                1: p = 16'h2345;
                2: p = 16'h0F0F;
                3: p = 16'hC321;
                4: p = 16'h4567;
                default: p = 16'h89AB;
              endcase
              p = p ^ 16'(a * 7 + ld * 3 + s);
              f = {2'(a), 2'(ld), 1'b0, 2'(s), 1'(cm), p};
              send_frame(f, tag_of(f));
            end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule